// File: doc/BRIEF.md
# Source-Routed Port Stripping Stage

This block is the route stage of one switch input in a network where the source node decides the whole path. A packet enters as a sequence of flits, each tagged with a two-bit kind. The head flit carries an ordered list of output port selects, one per switch on the path. The stage reads the select for this hop from the head. It removes that select so the next switch finds its own select in the same place, and forwards the shortened head to the chosen output. Body and tail flits follow on the same output with no further decision. The select for a hop is taken from the head alone. The choice is held for the whole packet, and the tail flit lets it go.

Both sides use valid/ready handshakes. A flit moves on a rising edge when valid and ready are both high. Once the source raises `in_valid` it must hold the flit stable until the stage accepts it. The stage keeps `out_valid` and every output field stable while `out_ready` is low. The stage has one output register. It can accept a new flit in the same cycle as its held flit leaves, so a stream passes at one flit per cycle with one cycle of latency.

Top module: `route_strip_stage`

## Requirements
- R1: During and directly after reset, `out_valid` and `path_held` are 0 and `in_ready` is 1.
- R2: For a flit whose kind has bit 0 set (01 head, 11 single-flit packet), `out_port` equals bits [2:0] of `in_data`, the leading port select.
- R3: For a head flit, the route region bits [11:0] leave the stage shifted right by 3, with bits [11:9] forced to zero. Bits [DATA_W-1:12] pass unchanged.
- R4: A body flit (kind 00) or tail flit (kind 10) leaves with `in_data` unchanged, and its `out_port` equals the port of the most recent head.
- R5: `path_held` goes to 1 after a head of kind 01 is accepted and stays at 1 through the body flits. It returns to 0 after the tail (10) is accepted. A single-flit packet (11) leaves it at 0.
- R6: `out_kind` equals the kind the flit was accepted with.
- R7: While `out_valid` is 1 and `out_ready` is 0, all output fields stay unchanged. Every accepted flit leaves exactly once and in order.
- R8: `in_ready` equals `!out_valid || out_ready`. A flit accepted on an edge is on the outputs with `out_valid` high after that edge.
- R9: `out_eject` is 1 exactly when the flit's `out_port` is 0, which means delivery to the local node.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Stage can take a flit |
| in_kind | input | 2 | Flit kind: 00 body, 01 head, 10 tail, 11 single |
| in_data | input | DATA_W (32) | Flit data; route fields in [11:0] of a head |
| out_valid | output | 1 | Output flit valid |
| out_ready | input | 1 | Ready of the chosen output |
| out_kind | output | 2 | Kind of the output flit |
| out_data | output | DATA_W (32) | Forwarded data, head rewritten |
| out_port | output | 3 | Output port chosen for this packet |
| out_eject | output | 1 | Port 0: deliver to local node |
| path_held | output | 1 | A multi-flit packet holds the path |

## Verification
Two things often fall in the same cycle: a stalled output, and an attempt to accept the next flit of the same packet or the head of a new one. The first is the hold rule. The second is the port choice or release at the packet boundary. The bench provokes this with random gaps on `out_ready`, driven against back-to-back packets that include single-flit ones. A reference queue filled at input handshakes is compared field by field at each output handshake. The bench also checks that a stalled flit is unchanged and that `path_held` follows the bench's own packet model every cycle.

// File: rtl/route_strip_pkg.sv
package route_strip_pkg;

  // Flit kind: bit 0 marks a packet start, bit 1 marks a packet end.
  typedef enum logic [1:0] {
    FK_BODY = 2'b00,
    FK_HEAD = 2'b01,
    FK_TAIL = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_e;

  function automatic logic kind_starts(input logic [1:0] k);
    return k[0];
  endfunction

  function automatic logic kind_ends(input logic [1:0] k);
    return k[1];
  endfunction

endpackage

// File: rtl/route_head_shift.sv
module route_head_shift #(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 3,
  parameter int NFIELDS = 4
) (
  input  logic [DATA_W-1:0]  data_i,
  output logic [FIELD_W-1:0] port_o,
  output logic [DATA_W-1:0]  data_o
);
  localparam int ROUTE_W = FIELD_W * NFIELDS;

  assign port_o = data_i[FIELD_W-1:0];

  // Each field moves one slot toward the least significant end; the top slot empties.
  for (genvar f = 0; f < NFIELDS; f++) begin : g_field
    if (f == NFIELDS - 1) begin : g_top
      assign data_o[f*FIELD_W +: FIELD_W] = '0;
    end else begin : g_move
      assign data_o[f*FIELD_W +: FIELD_W] = data_i[(f+1)*FIELD_W +: FIELD_W];
    end
  end

  if (DATA_W > ROUTE_W) begin : g_upper
    assign data_o[DATA_W-1:ROUTE_W] = data_i[DATA_W-1:ROUTE_W];
  end
endmodule

// File: rtl/route_path_hold.sv
module route_path_hold
  import route_strip_pkg::*;
#(
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [1:0]        kind_i,
  input  logic [PORT_W-1:0] head_port_i,
  output logic [PORT_W-1:0] sel_port_o,
  output logic              held_o
);
  logic [PORT_W-1:0] port_q;
  logic              held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      held_q <= 1'b0;
    end else if (take_i) begin
      if (kind_starts(kind_i)) begin
        port_q <= head_port_i;
        held_q <= !kind_ends(kind_i);
      end else if (kind_ends(kind_i)) begin
        held_q <= 1'b0;
      end
    end
  end

  assign sel_port_o = kind_starts(kind_i) ? head_port_i : port_q;
  assign held_o     = held_q;

  // R5: a single-flit packet never leaves the path held
  p_solo_no_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && kind_i == FK_SOLO) |=> !held_o);

  // R5: a multi-flit head reserves the path
  p_head_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && kind_i == FK_HEAD) |=> held_o);
endmodule

// File: rtl/route_out_stage.sv
module route_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_pl,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_pl
);
  logic         v_q;
  logic [W-1:0] pl_q;

  assign in_ready = !v_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else if (in_ready) v_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) pl_q <= in_pl;
  end

  assign out_valid = v_q;
  assign out_pl    = pl_q;

  // R7: a stalled flit stays put
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pl)));

  // R8: an accepted flit is presented on the next cycle
  p_accept_shows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/route_strip_stage.sv
module route_strip_stage
  import route_strip_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 3,
  parameter int NFIELDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [DATA_W-1:0] out_data,
  output logic [FIELD_W-1:0] out_port,
  output logic              out_eject,
  output logic              path_held
);
  localparam int ROUTE_W = FIELD_W * NFIELDS;
  localparam int PL_W    = 1 + FIELD_W + 2 + DATA_W;

  logic [FIELD_W-1:0] head_port;
  logic [DATA_W-1:0]  head_data;
  logic [FIELD_W-1:0] sel_port;
  logic [DATA_W-1:0]  fwd_data;
  logic               take;
  logic [PL_W-1:0]    pl_in, pl_out;

  route_head_shift #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .NFIELDS(NFIELDS)) u_shift (
    .data_i (in_data),
    .port_o (head_port),
    .data_o (head_data)
  );

  assign take = in_valid && in_ready;

  route_path_hold #(.PORT_W(FIELD_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take),
    .kind_i      (in_kind),
    .head_port_i (head_port),
    .sel_port_o  (sel_port),
    .held_o      (path_held)
  );

  assign fwd_data = kind_starts(in_kind) ? head_data : in_data;
  assign pl_in    = {(sel_port == '0), sel_port, in_kind, fwd_data};

  route_out_stage #(.W(PL_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pl     (pl_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pl    (pl_out)
  );

  assign {out_eject, out_port, out_kind, out_data} = pl_out;

  // Tracker of the port of the last head that left, for the port-consistency check.
  logic [FIELD_W-1:0] trk_port;
  logic               trk_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_port <= '0;
      trk_seen <= 1'b0;
    end else if (out_valid && out_ready && kind_starts(out_kind)) begin
      trk_port <= out_port;
      trk_seen <= 1'b1;
    end
  end

  // R4: body and tail flits leave on the head's port
  p_body_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !kind_starts(out_kind) && trk_seen) |-> (out_port == trk_port));

  // R3: a rewritten head has an empty top route field
  p_strip_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && kind_starts(out_kind)) |-> (out_data[ROUTE_W-1 -: FIELD_W] == '0));

  // R9: eject flag matches port zero
  p_eject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_eject == (out_port == '0)));
endmodule

// File: tb/route_strip_stage_test.sv
`timescale 1ns/100ps
module route_strip_stage_test;
  localparam int DW = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_kind = 2'b00;
  logic [DW-1:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [1:0]  out_kind;
  logic [DW-1:0] out_data;
  logic [2:0]  out_port;
  logic        out_eject;
  logic        path_held;

  always #2.5 clk = ~clk;

  route_strip_stage uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_kind(out_kind), .out_data(out_data),
    .out_port(out_port), .out_eject(out_eject), .path_held(path_held)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_strip(input logic [DW-1:0] d);
    logic [11:0] r;
    r = d[11:0] >> 3;
    return {d[DW-1:12], r};
  endfunction

  // Expected flit: {port, kind, data}
  logic [2+2+DW:0] expq[$];
  logic [2:0]  model_port = '0;
  logic        model_held = 1'b0;

  int pkt_left = 0;
  int pkts = 0;
  localparam int NPKT = 400;
  bit offering = 0;

  task automatic next_flit();
    logic [DW-1:0] d;
    int len;
    d = $urandom;
    if (pkt_left == 0) begin
      case (pkts)
        0: begin len = 3; d[11:0] = 12'hFFF; end   // port 7, every field set
        1: begin len = 1; d[11:0] = 12'h000; end   // single flit, eject
        2: begin len = 1; d[11:0] = 12'h9AD; end   // single flit, port 5
        3: begin len = 2; d[11:0] = 12'h008; end   // eject, next hop 1
        default: len = 1 + ($urandom % 4);
      endcase
      in_kind = (len == 1) ? 2'b11 : 2'b01;
      pkt_left = len - 1;
      pkts++;
    end else begin
      pkt_left--;
      in_kind = (pkt_left == 0) ? 2'b10 : 2'b00;
    end
    in_data = d;
    in_valid = 1'b1;
    offering = 1;
  endtask

  bit prev_in_fire = 0, prev_stall = 0;
  logic [1:0] sv_kind; logic [DW-1:0] sv_data; logic [2:0] sv_port; logic sv_ej;
  int cyc = 0;
  bit timeout = 0;

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    check(in_ready == 1, "R1 in_ready in reset", in_ready, 1);
    check(path_held == 0, "R1 path_held in reset", path_held, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(out_valid == 0 && path_held == 0, "R1 idle after reset", {out_valid, path_held}, 0);

    forever begin
      @(negedge clk);
      cyc++;
      // drive: keep an unaccepted flit, else maybe offer a new one
      if (prev_in_fire) offering = 0;
      if (!offering) begin
        in_valid = 1'b0;
        if (!(pkts >= NPKT && pkt_left == 0) && ($urandom % 5 != 0)) next_flit();
      end
      if (cyc > 40 && cyc < 52) out_ready = 1'b0;    // directed long stall
      else out_ready = ($urandom % 4 != 0);
      #1;
      // R8 ready rule and latency
      check(in_ready == (!out_valid || out_ready), "R8 in_ready rule", in_ready, !out_valid || out_ready);
      if (prev_in_fire) check(out_valid == 1, "R8 accepted flit shown", out_valid, 1);
      // R7 stall stability
      if (prev_stall) begin
        check(out_valid && out_kind == sv_kind && out_data == sv_data && out_port == sv_port && out_eject == sv_ej,
              "R7 stalled outputs stable", out_data, sv_data);
      end
      // R5 path held model
      check(path_held == model_held, "R5 path_held", path_held, model_held);
      // output handshake
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(0, "R7 unexpected extra flit", out_data, 0);
        end else begin
          logic [2+2+DW:0] e;
          e = expq.pop_front();
          check(out_port == e[DW+4:DW+2], out_kind[0] ? "R2 head port" : "R4 body port", out_port, e[DW+4:DW+2]);
          check(out_kind == e[DW+1:DW], "R6 kind", out_kind, e[DW+1:DW]);
          check(out_data == e[DW-1:0], out_kind[0] ? "R3 head rewrite" : "R4 data unchanged", out_data, e[DW-1:0]);
          check(out_eject == (e[DW+4:DW+2] == 0), "R9 eject", out_eject, e[DW+4:DW+2] == 0);
        end
      end
      // input handshake
      prev_in_fire = in_valid && in_ready;
      if (prev_in_fire) begin
        logic [DW-1:0] ed;
        if (in_kind[0]) begin
          model_port = in_data[2:0];
          ed = exp_strip(in_data);
          model_held = (in_kind == 2'b01);
        end else begin
          ed = in_data;
          if (in_kind == 2'b10) model_held = 1'b0;
        end
        expq.push_back({1'b0, model_port, in_kind, ed});
      end
      prev_stall = out_valid && !out_ready;
      sv_kind = out_kind; sv_data = out_data; sv_port = out_port; sv_ej = out_eject;
      if (pkts >= NPKT && pkt_left == 0 && !offering && expq.size() == 0 && !out_valid) break;
      if (cyc > 20000) begin timeout = 1; break; end
    end
    if (timeout) check(0, "watchdog expired", cyc, 20000);
    check(expq.size() == 0, "R7 all flits delivered", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule